// File: doc/BRIEF.md
# Shared-Memory SPI Slave Window

This block lets an external host processor reach a 512-byte communication memory over a four-wire SPI slave link, while a local CPU reads and writes the same memory through a single-cycle parallel port. The SPI pins are sampled by the local system clock through a synchronizer, so the serial clock has to run well below the system clock. The block needs at least five system clock periods per serial clock half period.

Each transaction opens with chip select going low and a two-byte header. The header holds a direction flag and the 9-bit start address. Data bytes follow until chip select rises. A configuration bit decides how the address moves between data bytes. When clear, the address steps up by one after every byte, for burst access. When set, the address stays on the start location, so one register can be drained or filled repeatedly. If both sides write in the same clock cycle, the host write takes the memory and the local CPU is told to retry.

Top module: `spi_reg_window`

## Requirements
- R1: The local port addresses 512 bytes with a 9-bit address. When `cpuWe` is high and `cpuStall` is low, `cpuWdata` is stored at `cpuAddr` on the clock edge. `cpuRdata` shows the byte at `cpuAddr` one clock after the address is applied.
- R2: The SPI link works in mode 0 with the most significant bit first. The host drives MOSI while SCLK is low, and the slave samples it on the rising SCLK edge. The first header byte carries the direction in bit 7 (1 = read, 0 = write) and address bit 8 in bit 0; its bits 6:1 are ignored. The second header byte carries address bits 7:0.
- R3: In a write transaction, each complete data byte after the header is stored at the current address.
- R4: In a read transaction, the byte at the current address is placed on MISO, MSB first, before the first rising SCLK edge of each data byte. MISO changes only after falling SCLK edges.
- R5: While the mode bit is 0, the address increases by one after each data byte, and it wraps from 511 to 0.
- R6: While the mode bit is 1, every data byte of the transaction uses the start address. A fixed-mode write therefore leaves only the last byte at that address, and the next addresses are untouched.
- R7: After reset the mode bit is 0.
- R8: The mode bit is written through `cfgWe`/`cfgFixed`. It is captured when the header completes, so changing it during the data phase does not affect the running transaction.
- R9: Chip select going high ends the transaction. A data byte cut short by fewer than 8 bits is not written. The next falling edge of chip select starts a new header.
- R10: When the SPI side and the local CPU write in the same cycle, the SPI byte is stored. `cpuStall` is high only in that cycle, and the CPU write is dropped.
- R11: MISO is 0 after reset and while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| spiCsN | input | 1 | SPI chip select, active low |
| spiSclk | input | 1 | SPI serial clock, idle low |
| spiMosi | input | 1 | SPI data from host |
| spiMiso | output | 1 | SPI data to host |
| cfgWe | input | 1 | Write strobe for the address-mode bit |
| cfgFixed | input | 1 | New mode bit value: 0 = increment, 1 = fixed |
| cpuAddr | input | 9 | Local CPU byte address |
| cpuWe | input | 1 | Local CPU write request |
| cpuWdata | input | 8 | Local CPU write data |
| cpuRdata | output | 8 | Local CPU read data, one cycle after address |
| cpuStall | output | 1 | Local write lost to an SPI write this cycle |

## Verification
Each SPI pin passes through two synchronizer flops and one edge register. A host byte therefore lands in memory about three system cycles after its eighth rising SCLK. Read data reaches MISO about three cycles after the falling SCLK edge that precedes it. The bench holds each SCLK level for five system cycles and samples MISO just before it raises SCLK. It reads memory through the local port only after chip select is released, sampling `cpuRdata` one full cycle after setting the address. `cpuStall` is combinational, so the bench watches it at every falling clock edge. It releases the CPU write right after the rising edge that follows the stall, which makes that rising edge the only collision.

// File: rtl/spi_window_pkg.sv
`timescale 1ns/1ps
package spi_window_pkg;

  // Strobes from the control path to the datapath
  typedef struct packed {
    logic we;       // store spiWdata at spiAddr
    logic loadTx;   // load prefetched byte into MISO shifter
    logic shiftTx;  // advance MISO shifter
    logic clearTx;  // chip deselected, flush shifter
  } spiStrobe_t;

  typedef enum logic [1:0] {
    PH_HDR_HI = 2'd0,
    PH_HDR_LO = 2'd1,
    PH_DATA   = 2'd2
  } spiPhase_t;

endpackage

// File: rtl/spi_window_ctrl.sv
`timescale 1ns/1ps
module spi_window_ctrl
  import spi_window_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiCsN,
  input  logic              spiSclk,
  input  logic              spiMosi,
  input  logic              cfgWe,
  input  logic              cfgFixed,
  output spiStrobe_t        strobe,
  output logic [ADDR_W-1:0] spiAddr,
  output logic [7:0]        spiWdata
);

  // Address bits carried in the first header byte (bit 7 is the direction)
  localparam int HI_BITS = ADDR_W - 8;

  logic [SYNC_STAGES-1:0] csPipe, sclkPipe, mosiPipe;
  logic                   sclkLast;
  logic                   csActive, sclkNow, mosiNow, sclkRise, sclkFall;

  logic [2:0]        bitCnt;
  spiPhase_t         phase;
  logic [6:0]        rxShift;
  logic [7:0]        rxByte;
  logic [HI_BITS-1:0] hdrAddrHi;
  logic              rdFlag;
  logic              modeFixed;
  logic              fixedLatched;
  logic [ADDR_W-1:0] curAddr;
  logic              byteDone;

  assign csActive = ~csPipe[SYNC_STAGES-1];
  assign sclkNow  = sclkPipe[SYNC_STAGES-1];
  assign mosiNow  = mosiPipe[SYNC_STAGES-1];
  assign sclkRise = sclkNow & ~sclkLast;
  assign sclkFall = ~sclkNow & sclkLast;
  assign rxByte   = {rxShift, mosiNow};
  assign byteDone = csActive & sclkRise & (bitCnt == 3'd7);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPipe       <= '1;
      sclkPipe     <= '0;
      mosiPipe     <= '0;
      sclkLast     <= 1'b0;
      bitCnt       <= '0;
      phase        <= PH_HDR_HI;
      rxShift      <= '0;
      hdrAddrHi    <= '0;
      rdFlag       <= 1'b0;
      modeFixed    <= 1'b0;
      fixedLatched <= 1'b0;
      curAddr      <= '0;
    end else begin
      csPipe   <= {csPipe[SYNC_STAGES-2:0], spiCsN};
      sclkPipe <= {sclkPipe[SYNC_STAGES-2:0], spiSclk};
      mosiPipe <= {mosiPipe[SYNC_STAGES-2:0], spiMosi};
      sclkLast <= sclkNow;
      if (cfgWe) modeFixed <= cfgFixed;

      if (!csActive) begin
        bitCnt <= '0;
        phase  <= PH_HDR_HI;
      end else if (sclkRise) begin
        rxShift <= rxByte[6:0];
        bitCnt  <= bitCnt + 3'd1;
        if (bitCnt == 3'd7) begin
          unique case (phase)
            PH_HDR_HI: begin
              rdFlag    <= rxByte[7];
              hdrAddrHi <= rxByte[HI_BITS-1:0];
              phase     <= PH_HDR_LO;
            end
            PH_HDR_LO: begin
              curAddr      <= {hdrAddrHi, rxByte};
              fixedLatched <= modeFixed;
              phase        <= PH_DATA;
            end
            PH_DATA: begin
              if (!fixedLatched) curAddr <= curAddr + 1'b1;
            end
            default: phase <= PH_HDR_HI;
          endcase
        end
      end
    end
  end

  always_comb begin
    strobe.we      = byteDone && (phase == PH_DATA) && !rdFlag;
    strobe.loadTx  = csActive && sclkFall && (bitCnt == 3'd0) &&
                     (phase == PH_DATA) && rdFlag;
    strobe.shiftTx = csActive && sclkFall && !strobe.loadTx;
    strobe.clearTx = !csActive;
  end

  assign spiAddr  = curAddr;
  assign spiWdata = rxByte;

  // R9: a deselected slave always restarts at the header
  p_idle_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |=> (bitCnt == 3'd0 && phase == PH_HDR_HI));

  // R5: a data byte in increment mode moves the address by one (wrapping)
  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (byteDone && phase == PH_DATA && !fixedLatched)
      |=> curAddr == ADDR_W'($past(curAddr) + 1'b1));

  // R6: in fixed mode the address never moves during the data phase
  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DATA && fixedLatched) |=> $stable(curAddr));

  // R8: the captured mode is frozen once data bytes flow
  p_mode_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DATA) |=> $stable(fixedLatched));

endmodule

// File: rtl/spi_window_dp.sv
`timescale 1ns/1ps
module spi_window_dp
  import spi_window_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStrobe_t        strobe,
  input  logic [ADDR_W-1:0] spiAddr,
  input  logic [7:0]        spiWdata,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWe,
  input  logic [7:0]        cpuWdata,
  output logic [7:0]        cpuRdata,
  output logic              cpuStall,
  output logic              spiMiso
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];
  logic [7:0] spiRd;
  logic [7:0] txShift;

  // Single write port: the serial side has priority
  assign cpuStall = cpuWe & strobe.we;

  always_ff @(posedge clk) begin
    if (strobe.we)  mem[spiAddr] <= spiWdata;
    else if (cpuWe) mem[cpuAddr] <= cpuWdata;
    cpuRdata <= mem[cpuAddr];
    spiRd    <= mem[spiAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               txShift <= '0;
    else if (strobe.clearTx) txShift <= '0;
    else if (strobe.loadTx)  txShift <= spiRd;
    else if (strobe.shiftTx) txShift <= {txShift[6:0], 1'b0};
  end

  assign spiMiso = txShift[7];

  // R3: a serial write is present in the array on the next cycle
  p_spi_write_lands_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.we |=> mem[$past(spiAddr)] == $past(spiWdata));

  // R1: an unstalled local write is present on the next cycle
  p_cpu_write_lands_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWe && !cpuStall) |=> mem[$past(cpuAddr)] == $past(cpuWdata));

  // R10: on a same-address collision the serial byte survives
  p_collision_spi_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cpuStall && cpuAddr == spiAddr) |=> mem[$past(cpuAddr)] == $past(spiWdata));

  // R11: a deselected slave drives MISO low
  p_miso_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearTx |=> !spiMiso);

endmodule

// File: rtl/spi_reg_window.sv
`timescale 1ns/1ps
module spi_reg_window
  import spi_window_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiCsN,
  input  logic              spiSclk,
  input  logic              spiMosi,
  output logic              spiMiso,
  input  logic              cfgWe,
  input  logic              cfgFixed,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWe,
  input  logic [7:0]        cpuWdata,
  output logic [7:0]        cpuRdata,
  output logic              cpuStall
);

  spiStrobe_t        strobe;
  logic [ADDR_W-1:0] spiAddr;
  logic [7:0]        spiWdata;

  spi_window_ctrl #(
    .ADDR_W(ADDR_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .spiCsN(spiCsN),
    .spiSclk(spiSclk),
    .spiMosi(spiMosi),
    .cfgWe(cfgWe),
    .cfgFixed(cfgFixed),
    .strobe(strobe),
    .spiAddr(spiAddr),
    .spiWdata(spiWdata)
  );

  spi_window_dp #(
    .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .spiAddr(spiAddr),
    .spiWdata(spiWdata),
    .cpuAddr(cpuAddr),
    .cpuWe(cpuWe),
    .cpuWdata(cpuWdata),
    .cpuRdata(cpuRdata),
    .cpuStall(cpuStall),
    .spiMiso(spiMiso)
  );

endmodule

// File: tb/spi_reg_window_test.sv
`timescale 1ns/1ps
module spi_reg_window_test;

  localparam int HALF = 100;  // SCLK half period, 5 system clocks

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       spiCsN = 1'b1, spiSclk = 1'b0, spiMosi = 1'b0;
  logic       spiMiso;
  logic       cfgWe = 1'b0, cfgFixed = 1'b0;
  logic [8:0] cpuAddr = '0;
  logic       cpuWe = 1'b0;
  logic [7:0] cpuWdata = '0;
  logic [7:0] cpuRdata;
  logic       cpuStall;

  int checks = 0;
  int fails  = 0;
  int stallCnt = 0;

  logic [7:0] refMem [0:511];
  logic [7:0] txBuf  [0:519];
  logic [7:0] rxBuf  [0:519];

  always #10 clk = ~clk;  // 50 MHz

  spi_reg_window uut (
    .clk(clk), .rstN(rstN),
    .spiCsN(spiCsN), .spiSclk(spiSclk), .spiMosi(spiMosi), .spiMiso(spiMiso),
    .cfgWe(cfgWe), .cfgFixed(cfgFixed),
    .cpuAddr(cpuAddr), .cpuWe(cpuWe), .cpuWdata(cpuWdata),
    .cpuRdata(cpuRdata), .cpuStall(cpuStall)
  );

  always @(negedge clk) if (cpuStall) stallCnt++;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction

  task automatic cpuWrite(input logic [8:0] a, input logic [7:0] d);
    @(negedge clk); cpuAddr = a; cpuWdata = d; cpuWe = 1'b1;
    @(negedge clk); cpuWe = 1'b0;
  endtask

  task automatic cpuCheck(input string req, input logic [8:0] a);
    @(negedge clk); cpuAddr = a;
    @(negedge clk); chk(req, {8'h0, cpuRdata}, {8'h0, refMem[a]});
  endtask

  task automatic setMode(input logic v);
    @(negedge clk); cfgWe = 1'b1; cfgFixed = v;
    @(negedge clk); cfgWe = 1'b0;
  endtask

  // Header byte 0 carries filler 101101 in the ignored bits 6:1 (R2)
  task automatic spiXfer(input logic rd, input logic [8:0] a, input int nData,
                         input int extra, input logic flip);
    logic [15:0] hdr;
    int total;
    hdr   = {rd, 6'b101101, a[8], a[7:0]};
    total = 16 + 8 * nData + extra;
    @(negedge clk); spiCsN = 1'b0; #(HALF);
    for (int i = 0; i < total; i++) begin
      if (i < 16) spiMosi = hdr[15 - i];
      else        spiMosi = txBuf[(i - 16) / 8][7 - ((i - 16) % 8)];
      #(HALF);
      if (i >= 16) rxBuf[(i - 16) / 8] = {rxBuf[(i - 16) / 8][6:0], spiMiso};
      spiSclk = 1'b1;
      #(HALF);
      spiSclk = 1'b0;
      if (flip && i == 15) begin
        @(negedge clk); cfgWe = 1'b1; cfgFixed = ~cfgFixed;
        @(negedge clk); cfgWe = 1'b0;
      end
    end
    #(HALF); spiCsN = 1'b1; spiMosi = 1'b0;
    #(4 * HALF);
    chk("R11 miso low when deselected", {15'h0, spiMiso}, 16'h0);
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic hit;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11 miso after reset", {15'h0, spiMiso}, 16'h0);
    chk("R10 no stall after reset", {15'h0, cpuStall}, 16'h0);

    // R1: fill the whole window from the local port and read it back
    for (int a = 0; a < 512; a++) begin
      cpuWrite(9'(a), pat(a));
      refMem[a] = pat(a);
    end
    for (int a = 0; a < 512; a++) cpuCheck("R1 local readback", 9'(a));

    // R7/R5/R3: default mode increments, write burst wraps 511 -> 0
    for (int k = 0; k < 4; k++) txBuf[k] = 8'h11 * 8'(k + 1);
    spiXfer(1'b0, 9'd510, 4, 0, 1'b0);
    refMem[510] = txBuf[0]; refMem[511] = txBuf[1];
    refMem[0]   = txBuf[2]; refMem[1]   = txBuf[3];
    cpuCheck("R7 R5 R3 write 510", 9'd510);
    cpuCheck("R5 R3 write 511", 9'd511);
    cpuCheck("R5 wrap write 0", 9'd0);
    cpuCheck("R5 write 1", 9'd1);
    cpuCheck("R3 neighbour 2 untouched", 9'd2);
    cpuCheck("R3 neighbour 509 untouched", 9'd509);

    // R4/R2: read the full window in one increment burst
    spiXfer(1'b1, 9'd0, 512, 0, 1'b0);
    for (int a = 0; a < 512; a++)
      chk("R4 R2 full burst read", {8'h0, rxBuf[a]}, {8'h0, refMem[a]});

    // R5: read burst across the wrap point
    spiXfer(1'b1, 9'd505, 10, 0, 1'b0);
    for (int k = 0; k < 10; k++)
      chk("R5 wrap read", {8'h0, rxBuf[k]}, {8'h0, refMem[(505 + k) % 512]});

    // R6: fixed mode reads and writes stay on one address
    setMode(1'b1);
    spiXfer(1'b1, 9'd100, 4, 0, 1'b0);
    for (int k = 0; k < 4; k++)
      chk("R6 fixed read", {8'h0, rxBuf[k]}, {8'h0, refMem[100]});
    txBuf[0] = 8'hA1; txBuf[1] = 8'hB2; txBuf[2] = 8'hC3;
    spiXfer(1'b0, 9'd200, 3, 0, 1'b0);
    refMem[200] = 8'hC3;
    cpuCheck("R6 fixed write last byte", 9'd200);
    cpuCheck("R6 fixed write 201 untouched", 9'd201);
    cpuCheck("R6 fixed write 202 untouched", 9'd202);

    // R8: mode change after the header does not affect the transaction
    setMode(1'b0);
    txBuf[0] = 8'h3C; txBuf[1] = 8'h4D; txBuf[2] = 8'h5E;
    spiXfer(1'b0, 9'd40, 3, 0, 1'b1);  // flips to fixed mid-way
    refMem[40] = 8'h3C; refMem[41] = 8'h4D; refMem[42] = 8'h5E;
    cpuCheck("R8 increment kept 40", 9'd40);
    cpuCheck("R8 increment kept 41", 9'd41);
    cpuCheck("R8 increment kept 42", 9'd42);
    txBuf[0] = 8'h6F; txBuf[1] = 8'h70;
    spiXfer(1'b0, 9'd60, 2, 0, 1'b1);  // fixed, flips to increment mid-way
    refMem[60] = 8'h70;
    cpuCheck("R8 fixed kept 60", 9'd60);
    cpuCheck("R8 fixed kept 61 untouched", 9'd61);

    // R9: truncated second byte is discarded, next header restarts cleanly
    txBuf[0] = 8'h81; txBuf[1] = 8'h92;
    spiXfer(1'b0, 9'd80, 1, 5, 1'b0);
    refMem[80] = 8'h81;
    cpuCheck("R9 full byte stored", 9'd80);
    cpuCheck("R9 partial byte dropped", 9'd81);
    spiXfer(1'b1, 9'd81, 1, 0, 1'b0);
    chk("R9 new header after deselect", {8'h0, rxBuf[0]}, {8'h0, refMem[81]});

    // R10: collision on the write port
    txBuf[0] = 8'h5A;
    stallCnt = 0;
    hit = 1'b0;
    fork
      spiXfer(1'b0, 9'd300, 1, 0, 1'b0);
      begin
        @(negedge clk); cpuAddr = 9'd300; cpuWdata = 8'hC3; cpuWe = 1'b1;
        for (int k = 0; k < 2000 && !hit; k++) begin
          @(negedge clk);
          if (cpuStall) hit = 1'b1;
        end
        @(posedge clk); #1; cpuWe = 1'b0;
      end
    join
    refMem[300] = 8'h5A;
    chk("R10 stall raised", {15'h0, hit}, 16'h1);
    chk("R10 stall for one cycle only", 16'(stallCnt), 16'd1);
    cpuCheck("R10 serial byte wins", 9'd300);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule